// File: doc/BRIEF.md
# Recursive Sine Resonator

This block produces a sampled sine wave without any stored waveform table. It keeps the two most recent samples and one fixed-point coefficient. On every enabled sample it forms the next sample as the coefficient times the newer sample, minus the older sample. The two samples then slide down by one place. The host chooses the tone by writing the coefficient, whose value is 2 − (2π·f_tone/f_sample)². For a low tone relative to the sample rate, this value sits just under 2.

A load pulse latches a new coefficient and restarts the state at zero and unity, so the output restarts as a sine from phase zero. The load pulse is how a frequency change is made. It also clears accumulated amplitude or phase drift without a full reset. Starting from zero and unity, the peak of the output is unity divided by sin(2π·f_tone/f_sample), roughly 16 for a 440 Hz tone at 44.1 kHz. The state is therefore wider than the unity point by enough headroom to hold that peak. Each sample costs one multiply, one rounding shift and one saturating subtract. The result reaches a registered output with a one-cycle valid strobe.

Top module: `sine_resonator`

## Requirements
- R1: While reset is high and in the cycle after it, `sample_out` is 0 and `sample_vld` is 0. Reset also sets the coefficient to 0, the older sample to 0 and the newer sample to unity (2^FRAC_W).
- R2: On a rising edge with `sample_en` = 1 and `load` = 0, the new sample is computed as q − x0. Here q is the rounded product of the coefficient and the newer sample x1. After the edge, the older sample takes the value of x1 and the newer sample takes the new value.
- R3: q is the full-width signed product shifted right by FRAC_W with round to nearest, ties toward +∞. In other words, floor((coef·x1 + 2^(FRAC_W−1)) / 2^FRAC_W). The coefficient is a signed two's-complement value with FRAC_W fraction bits, so 2^FRAC_W means 1.0.
- R4: The result of the subtraction saturates to the signed STATE_W range, from −2^(STATE_W−1) to 2^(STATE_W−1)−1, and does not wrap.
- R5: `sample_out` takes the new sample, and `sample_vld` is 1 for exactly one cycle, on the edge that follows each edge of R2. `sample_vld` is 0 in every other cycle.
- R6: With `sample_en` = 0 and `load` = 0, the state does not change, no valid strobe appears and `sample_out` holds its value. When enabling resumes, the sequence continues from where it stopped.
- R7: On an edge with `load` = 1, the older sample is set to 0, the newer sample to unity, and the coefficient is taken from `coef_in`. Load has priority over `sample_en`: no sample is produced on that edge. The first sample after a load therefore equals round(coef·unity/2^FRAC_W) = coef.
- R8: With the coefficient for 440 Hz at 44100 Hz (130814 at FRAC_W = 16), the first sample is 130814. The output follows a real-valued model of the same recurrence to within 4096 LSB over 520 samples. The mean spacing between rising zero crossings lies between 99.7 and 100.7 samples.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_en | input | 1 | Advance the recurrence by one sample on this edge |
| load | input | 1 | Restart the state and latch `coef_in` |
| coef_in | input | COEF_W | Signed coefficient, FRAC_W fraction bits |
| sample_out | output | STATE_W | Signed output sample, unity = 2^FRAC_W |
| sample_vld | output | 1 | One-cycle strobe marking a new `sample_out` |

## Verification
The bench builds the block with its defaults: an 18-bit coefficient with 16 fraction bits and 22-bit state. With these widths, the 440 Hz coefficient just below 2.0 can be represented, and the full peak of about 16 times unity fits without clipping. A coefficient of −2.0 drives the state into both saturation limits within a few dozen samples. Odd and negative coefficients make the rounding ties and the floor of negative products visible in the low bits. Every output is compared bit for bit against an integer model of the stated rounding and clamping rules. The 440 Hz run is also held against a real-valued model and against its zero-crossing period.

// File: rtl/sres_pkg.sv
package sres_pkg;
  typedef enum logic [1:0] {
    CMD_HOLD = 2'd0,
    CMD_STEP = 2'd1,
    CMD_LOAD = 2'd2
  } sres_cmd_e;
endpackage

// File: rtl/sres_mul_round.sv
module sres_mul_round #(
  parameter int COEF_W        = 18,
  parameter int STATE_W       = 22,
  parameter int FRAC_W        = 16,
  parameter bit ROUND_NEAREST = 1'b1,
  localparam int PW = COEF_W + STATE_W,
  localparam int RW = PW - FRAC_W
) (
  input  logic signed [COEF_W-1:0]  coef,
  input  logic signed [STATE_W-1:0] x1,
  output logic signed [RW-1:0]      prod_q
);
  logic signed [PW-1:0] coef_ext;
  logic signed [PW-1:0] x1_ext;
  logic signed [PW-1:0] prod;

  assign coef_ext = PW'(coef);
  assign x1_ext   = PW'(x1);
  assign prod     = coef_ext * x1_ext;

  generate
    if (ROUND_NEAREST) begin : g_round
      localparam logic signed [PW-1:0] HALF =
        {{(PW-FRAC_W){1'b0}}, 1'b1, {(FRAC_W-1){1'b0}}};
      logic signed [PW-1:0] biased;
      assign biased = prod + HALF;
      assign prod_q = RW'(biased >>> FRAC_W);
    end else begin : g_floor
      assign prod_q = RW'(prod >>> FRAC_W);
    end
  endgenerate
endmodule

// File: rtl/sres_sat_sub.sv
module sres_sat_sub #(
  parameter int IN_W  = 24,
  parameter int OUT_W = 22,
  localparam int DW = IN_W + 1
) (
  input  logic signed [IN_W-1:0]  a,
  input  logic signed [OUT_W-1:0] b,
  output logic signed [OUT_W-1:0] y
);
  localparam logic signed [OUT_W-1:0] YMAX = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic signed [OUT_W-1:0] YMIN = {1'b1, {(OUT_W-1){1'b0}}};

  logic signed [DW-1:0] diff;

  always_comb begin
    diff = DW'(a) - DW'(b);
    if (diff > DW'(YMAX))      y = YMAX;
    else if (diff < DW'(YMIN)) y = YMIN;
    else                       y = OUT_W'(diff);
  end

  initial begin
    AST_WIDTH_OK: assert (IN_W >= OUT_W); // R4
  end
endmodule

// File: rtl/sres_state.sv
module sres_state
  import sres_pkg::*;
#(
  parameter int COEF_W  = 18,
  parameter int STATE_W = 22,
  parameter int FRAC_W  = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  sres_cmd_e                 cmd,
  input  logic signed [COEF_W-1:0]  coef_in,
  input  logic signed [STATE_W-1:0] nxt,
  output logic signed [COEF_W-1:0]  coef,
  output logic signed [STATE_W-1:0] x0,
  output logic signed [STATE_W-1:0] x1
);
  localparam logic signed [STATE_W-1:0] UNITY =
    {{(STATE_W-FRAC_W-1){1'b0}}, 1'b1, {FRAC_W{1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      coef <= '0;
      x0   <= '0;
      x1   <= UNITY;
    end else begin
      case (cmd)
        CMD_LOAD: begin
          coef <= coef_in;
          x0   <= '0;
          x1   <= UNITY;
        end
        CMD_STEP: begin
          x0 <= x1;
          x1 <= nxt;
        end
        default: ;
      endcase
    end
  end

  AST_SHIFT_DOWN: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_STEP) |=> (x0 == $past(x1))); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_HOLD) |=> ($stable(x0) && $stable(x1) && $stable(coef))); // R6
  AST_LOAD_RESTART: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_LOAD) |=> (x0 == '0 && x1 == UNITY && coef == $past(coef_in))); // R7
endmodule

// File: rtl/sine_resonator.sv
module sine_resonator
  import sres_pkg::*;
#(
  parameter int COEF_W        = 18,
  parameter int STATE_W       = 22,
  parameter int FRAC_W        = 16,
  parameter bit ROUND_NEAREST = 1'b1,
  localparam int RW = COEF_W + STATE_W - FRAC_W
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      sample_en,
  input  logic                      load,
  input  logic signed [COEF_W-1:0]  coef_in,
  output logic signed [STATE_W-1:0] sample_out,
  output logic                      sample_vld
);
  sres_cmd_e                 cmd;
  logic signed [COEF_W-1:0]  coef;
  logic signed [STATE_W-1:0] x0;
  logic signed [STATE_W-1:0] x1;
  logic signed [STATE_W-1:0] nxt;
  logic signed [RW-1:0]      prod_q;
  logic                      step_q;

  always_comb begin
    if (load)           cmd = CMD_LOAD;
    else if (sample_en) cmd = CMD_STEP;
    else                cmd = CMD_HOLD;
  end

  sres_mul_round #(
    .COEF_W(COEF_W), .STATE_W(STATE_W), .FRAC_W(FRAC_W),
    .ROUND_NEAREST(ROUND_NEAREST)
  ) u_mul (
    .coef(coef), .x1(x1), .prod_q(prod_q)
  );

  sres_sat_sub #(.IN_W(RW), .OUT_W(STATE_W)) u_sub (
    .a(prod_q), .b(x0), .y(nxt)
  );

  sres_state #(.COEF_W(COEF_W), .STATE_W(STATE_W), .FRAC_W(FRAC_W)) u_state (
    .clk(clk), .rst(rst), .cmd(cmd), .coef_in(coef_in), .nxt(nxt),
    .coef(coef), .x0(x0), .x1(x1)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q     <= 1'b0;
      sample_vld <= 1'b0;
      sample_out <= '0;
    end else begin
      step_q     <= (cmd == CMD_STEP);
      sample_vld <= step_q;
      if (step_q) sample_out <= x1;
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (sample_vld == 1'b0 && sample_out == '0)); // R1
  AST_VALID_TIMING: assert property (@(posedge clk) disable iff (rst)
    sample_vld == $past(sample_en && !load && !rst, 2)); // R5
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !sample_vld |-> $stable(sample_out)); // R6
endmodule

// File: tb/sine_resonator_tb_top.sv
module sine_resonator_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int COEF_W  = 18;
  localparam int STATE_W = 22;
  localparam int FRAC_W  = 16;
  localparam longint UNITY = longint'(1) <<< FRAC_W;
  localparam longint SMAX  = (longint'(1) <<< (STATE_W-1)) - 1;
  localparam longint SMIN  = -(longint'(1) <<< (STATE_W-1));
  localparam int NREC = 520;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sample_en = 1'b0;
  logic load = 1'b0;
  logic signed [COEF_W-1:0]  coef_in = '0;
  logic signed [STATE_W-1:0] sample_out;
  logic sample_vld;

  always #(CLK_PERIOD/2) clk = ~clk;

  sine_resonator #(.COEF_W(COEF_W), .STATE_W(STATE_W), .FRAC_W(FRAC_W)) dut_i (
    .clk(clk), .rst(rst), .sample_en(sample_en), .load(load),
    .coef_in(coef_in), .sample_out(sample_out), .sample_vld(sample_vld)
  );

  int checks = 0;
  int fails = 0;
  longint q[$];
  longint mx0 = 0, mx1 = UNITY, ma = 0;
  string cur_req = "R2";
  bit rec_on = 1'b0;
  int rec_n = 0;
  longint rec[NREC];
  bit hit_max = 1'b0, hit_min = 1'b0;
  bit done = 1'b0;

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint model_next(longint a, longint x1, longint x0);
    longint p, r, d;
    p = a * x1;
    r = (p + (longint'(1) <<< (FRAC_W-1))) >>> FRAC_W;
    d = r - x0;
    if (d > SMAX) d = SMAX;
    if (d < SMIN) d = SMIN;
    return d;
  endfunction

  // driver: one cycle of stimulus, expected sample pushed into the scoreboard
  task automatic tick(bit en, bit ld, longint c);
    longint n;
    sample_en = en;
    load = ld;
    coef_in = c[COEF_W-1:0];
    if (ld) begin
      mx0 = 0; mx1 = UNITY; ma = c;
    end else if (en) begin
      n = model_next(ma, mx1, mx0);
      q.push_back(n);
      mx0 = mx1; mx1 = n;
    end
    @(negedge clk);
  endtask

  task automatic drain();
    for (int i = 0; i < 4; i++) tick(1'b0, 1'b0, 0);
  endtask

  // monitor: pop and compare every produced sample
  always @(negedge clk) begin
    if (!rst && sample_vld && !done) begin
      if (q.size() == 0) begin
        check(1'b0, "R5", longint'(sample_out), 0);
      end else begin
        longint e;
        e = q.pop_front();
        check(longint'(sample_out) == e, cur_req, longint'(sample_out), e);
        if (rec_on && rec_n < NREC) begin
          rec[rec_n] = longint'(sample_out);
          rec_n++;
        end
        if (longint'(sample_out) == SMAX) hit_max = 1'b1;
        if (longint'(sample_out) == SMIN) hit_min = 1'b1;
      end
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    real ar, r0, r1, r2, err, maxerr, per;
    longint c440, prev_out;
    int first_x, last_x, nx;

    // R1: reset state
    repeat (3) @(negedge clk);
    check(sample_out == '0 && !sample_vld, "R1", longint'(sample_out), 0);
    rst = 1'b0;
    @(negedge clk);
    check(sample_out == '0 && !sample_vld, "R1", longint'(sample_out), 0);

    // R8: 440 Hz tone at 44100 Hz
    ar = 2.0 - (2.0 * 3.14159265358979 * 440.0 / 44100.0) ** 2;
    c440 = longint'(ar * real'(UNITY));
    check(c440 == 130814, "R8", c440, 130814);
    cur_req = "R8";
    tick(1'b0, 1'b1, c440);
    rec_on = 1'b1;
    for (int i = 0; i < NREC; i++) tick(1'b1, 1'b0, c440);
    drain();
    rec_on = 1'b0;
    check(rec[0] == 130814, "R8", rec[0], 130814);
    ar = real'(c440) / real'(UNITY);
    r0 = 0.0; r1 = 1.0; maxerr = 0.0;
    for (int i = 0; i < NREC; i++) begin
      r2 = ar * r1 - r0;
      r0 = r1; r1 = r2;
      err = real'(rec[i]) - r2 * real'(UNITY);
      if (err < 0.0) err = -err;
      if (err > maxerr) maxerr = err;
    end
    check(maxerr <= 4096.0, "R8", longint'(maxerr), 4096);
    first_x = -1; last_x = -1; nx = 0;
    for (int i = 1; i < NREC; i++) begin
      if (rec[i-1] < 0 && rec[i] >= 0) begin
        if (first_x < 0) first_x = i;
        last_x = i;
        nx++;
      end
    end
    per = (nx > 1) ? real'(last_x - first_x) / real'(nx - 1) : 0.0;
    check(per > 99.7 && per < 100.7, "R8", longint'(per * 10.0), 1002);

    // R6: gaps in the enable keep the sequence intact
    cur_req = "R6";
    prev_out = longint'(sample_out);
    for (int i = 0; i < 5; i++) begin
      tick(1'b0, 1'b0, 0);
      check(!sample_vld && longint'(sample_out) == prev_out, "R6",
            longint'(sample_out), prev_out);
    end
    for (int i = 0; i < 40; i++) tick((i % 3) != 1, 1'b0, 0);
    drain();

    // R2: zero coefficient gives the period-4 pattern 0, -1, 0, +1
    cur_req = "R2";
    tick(1'b0, 1'b1, 0);
    for (int i = 0; i < 12; i++) tick(1'b1, 1'b0, 0);
    drain();

    // R3: rounding with odd positive and negative coefficients
    cur_req = "R3";
    tick(1'b0, 1'b1, 76543);
    for (int i = 0; i < 60; i++) tick(1'b1, 1'b0, 76543);
    drain();
    tick(1'b0, 1'b1, -70001);
    for (int i = 0; i < 60; i++) tick(1'b1, 1'b0, -70001);
    drain();

    // R4: coefficient -2.0 runs into both limits
    cur_req = "R4";
    hit_max = 1'b0; hit_min = 1'b0;
    tick(1'b0, 1'b1, -131072);
    for (int i = 0; i < 60; i++) tick(1'b1, 1'b0, -131072);
    drain();
    check(hit_max, "R4", longint'(hit_max), 1);
    check(hit_min, "R4", longint'(hit_min), 1);

    // R7: load together with enable produces nothing and restarts
    cur_req = "R7";
    tick(1'b0, 1'b1, 100000);
    for (int i = 0; i < 7; i++) tick(1'b1, 1'b0, 100000);
    tick(1'b1, 1'b1, 91234);
    drain();
    tick(1'b1, 1'b1, 91234);
    tick(1'b0, 1'b0, 0);
    check(!sample_vld, "R7", longint'(sample_vld), 0);
    tick(1'b0, 1'b0, 0);
    check(!sample_vld, "R7", longint'(sample_vld), 0);
    tick(1'b1, 1'b0, 0);
    tick(1'b0, 1'b0, 0);
    check(sample_vld && longint'(sample_out) == 91234, "R7",
          longint'(sample_out), 91234);
    drain();

    // R5: every pushed sample was seen
    check(q.size() == 0, "R5", longint'(q.size()), 0);
    finish_run();
  end
endmodule